// File: doc/BRIEF.md
# Serial Gain-Control Register Interface

This block receives write-only control frames over a two-wire serial link (a clock and a data line, with no chip select) and keeps the gain and knee settings for a camera front end. The serial clock comes from an external controller and is far slower than the system clock. The block passes both lines through synchronizers and finds the serial clock's falling edges by oversampling.

Each frame has ten data bits, sent from D10 down to D1. The receiver then needs one more falling edge with the data line high before it commits the frame. The two lowest-numbered bits, D1 and D2, choose which register group the payload goes to:

- a 5-bit knee level packed together with a 3-bit gain-select code,
- a 7-bit AGC gain code,
- a single pulse-selection bit.

The fourth selector value is reserved. Every committed write produces a one-cycle update strobe, so downstream logic can pick up the new setting.

Top module: `serial_gain_port`

## Requirements
- R1: While `rst` is high at a rising `clk` edge, all four output registers go to zero, `upd_stb` goes low, and any partly received frame is thrown away.
- R2: A data bit is taken on each falling edge of `ser_clk`. D10 is taken first and D1 last. After ten bits, the eleventh falling edge commits the frame only if `ser_dat` is high at that edge.
- R3: If `ser_dat` is low at the eleventh falling edge, the frame is dropped. No register changes and no strobe is produced. The next falling edge starts a new frame.
- R4: Selector D1=0, D2=0 writes two fields at once. `knee_lvl` takes D7..D3, with D3 as its LSB. `gain_sel` takes D10..D8, with D8 as its LSB; code 000 is the lowest gain and 111 the highest. `agc_code` and `pulse_sel` keep their values.
- R5: Selector D1=0, D2=1 writes `agc_code` from D9..D3, with D3 as the LSB; 0 is minimum gain and 127 is maximum. D10 is ignored. The other registers keep their values.
- R6: Selector D1=1, D2=0 writes `pulse_sel` from D3. D4 to D10 are ignored. The other registers keep their values.
- R7: Selector D1=1, D2=1 is reserved. A committed frame carrying it changes no register and produces no strobe.
- R8: `upd_stb` is high for exactly one `clk` cycle for each committed write. It is high in the same cycle that the new register value first appears at the outputs, and at no other time.
- R9: Frames are received correctly at any `ser_clk` period from 2 µs to 20 µs, with a 100 MHz `clk`.
- R10: Between strobes, all output registers hold their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; oversamples the serial lines |
| rst | input | 1 | Synchronous reset, active high |
| ser_clk | input | 1 | Serial clock from the external controller; idles high |
| ser_dat | input | 1 | Serial data, sampled on falling edges of `ser_clk` |
| knee_lvl | output | 5 | Knee level setting |
| gain_sel | output | 3 | Gain-select code, 000 lowest to 111 highest |
| agc_code | output | 7 | AGC gain code, 0 lowest to 127 highest |
| pulse_sel | output | 1 | Stored pulse-selection bit |
| upd_stb | output | 1 | One-cycle pulse on each register write |

## Verification
The hardest cases to reach from the ports are frames that end without a commit. One kind is a frame whose eleventh edge has the data line low. The other is a frame that is committed but carries the reserved selector. In both cases a correct design does nothing, and the only evidence of a fault would be a stray strobe or a wrong bit count that corrupts the next frame. For that reason, the stimulus sends each of these frames and then checks every output against the bench model and counts the strobes. It then sends a valid frame immediately after, which shows that the bit counter went back to zero. Stimulus at both the 2 µs and the 20 µs serial clock periods covers the synchronizer and edge detector across the whole range of oversampling ratios.

// File: rtl/sgp_pkg.sv
package sgp_pkg;

    localparam int FRAME_BITS = 10;
    localparam int KNEE_W     = 5;
    localparam int GSEL_W     = 3;
    localparam int AGC_W      = 7;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);

    // Bit index k-1 of a frame holds data bit Dk.
    localparam int PAYLOAD_LSB = 2;
    localparam int KNEE_LSB    = PAYLOAD_LSB;
    localparam int GSEL_LSB    = KNEE_LSB + KNEE_W;
    localparam int AGC_LSB     = PAYLOAD_LSB;
    localparam int PSEL_BIT    = PAYLOAD_LSB;

    typedef logic [FRAME_BITS-1:0] frame_t;

    // Selector value is {D2, D1}.
    typedef enum logic [1:0] {
        FN_KNEE_GAIN = 2'b00,
        FN_PULSE     = 2'b01,
        FN_AGC       = 2'b10,
        FN_RESERVED  = 2'b11
    } func_e;

    typedef struct packed {
        logic [KNEE_W-1:0] knee;
        logic [GSEL_W-1:0] gsel;
        logic [AGC_W-1:0]  agc;
        logic              psel;
    } ctrl_regs_t;

    function automatic func_e frame_func(input frame_t f);
        return func_e'(f[1:0]);
    endfunction

    function automatic logic [KNEE_W-1:0] frame_knee(input frame_t f);
        return f[KNEE_LSB +: KNEE_W];
    endfunction

    function automatic logic [GSEL_W-1:0] frame_gsel(input frame_t f);
        return f[GSEL_LSB +: GSEL_W];
    endfunction

    function automatic logic [AGC_W-1:0] frame_agc(input frame_t f);
        return f[AGC_LSB +: AGC_W];
    endfunction

    function automatic logic frame_psel(input frame_t f);
        return f[PSEL_BIT];
    endfunction

endpackage

// File: rtl/sgp_sync.sv
module sgp_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= {STAGES{RST_VAL}};
        end else begin
            chain <= {chain[STAGES-2:0], d};
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/sgp_frame_rx.sv
module sgp_frame_rx
    import sgp_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sck_s,
    input  logic             sdat_s,
    output frame_t           frame,
    output logic             commit,
    output logic [CNT_W-1:0] bit_cnt
);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(FRAME_BITS);

    logic   sck_q;
    logic   fall;
    frame_t shreg;

    assign fall = sck_q & ~sck_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q   <= 1'b1;
            shreg   <= '0;
            bit_cnt <= '0;
            commit  <= 1'b0;
        end else begin
            sck_q  <= sck_s;
            commit <= 1'b0;
            if (fall) begin
                if (bit_cnt == LAST_CNT) begin
                    bit_cnt <= '0;
                    commit  <= sdat_s;
                end else begin
                    shreg   <= {shreg[FRAME_BITS-2:0], sdat_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end
        end
    end

    assign frame = shreg;
endmodule

// File: rtl/sgp_reg_bank.sv
module sgp_reg_bank
    import sgp_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       commit,
    input  frame_t     frame,
    output ctrl_regs_t regs,
    output logic       upd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            regs <= '0;
            upd  <= 1'b0;
        end else begin
            upd <= 1'b0;
            if (commit) begin
                unique case (frame_func(frame))
                    FN_KNEE_GAIN: begin
                        regs.knee <= frame_knee(frame);
                        regs.gsel <= frame_gsel(frame);
                        upd       <= 1'b1;
                    end
                    FN_AGC: begin
                        regs.agc <= frame_agc(frame);
                        upd      <= 1'b1;
                    end
                    FN_PULSE: begin
                        regs.psel <= frame_psel(frame);
                        upd       <= 1'b1;
                    end
                    FN_RESERVED: begin
                        upd <= 1'b0;
                    end
                endcase
            end
        end
    end
endmodule

// File: rtl/serial_gain_port.sv
module serial_gain_port
    import sgp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk,
    input  logic              ser_dat,
    output logic [KNEE_W-1:0] knee_lvl,
    output logic [GSEL_W-1:0] gain_sel,
    output logic [AGC_W-1:0]  agc_code,
    output logic              pulse_sel,
    output logic              upd_stb
);
    logic             sck_s;
    logic             sdat_s;
    frame_t           frame;
    logic             commit;
    logic [CNT_W-1:0] bit_cnt;
    ctrl_regs_t       regs;

    sgp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_clk (
        .clk(clk), .rst(rst), .d(ser_clk), .q(sck_s)
    );

    sgp_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_dat (
        .clk(clk), .rst(rst), .d(ser_dat), .q(sdat_s)
    );

    sgp_frame_rx u_rx (
        .clk(clk), .rst(rst), .sck_s(sck_s), .sdat_s(sdat_s),
        .frame(frame), .commit(commit), .bit_cnt(bit_cnt)
    );

    sgp_reg_bank u_bank (
        .clk(clk), .rst(rst), .commit(commit), .frame(frame),
        .regs(regs), .upd(upd_stb)
    );

    assign knee_lvl  = regs.knee;
    assign gain_sel  = regs.gsel;
    assign agc_code  = regs.agc;
    assign pulse_sel = regs.psel;
endmodule

// File: rtl/serial_gain_port_chk.sv
module serial_gain_port_chk
    import sgp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic [KNEE_W-1:0] knee_lvl,
    input logic [GSEL_W-1:0] gain_sel,
    input logic [AGC_W-1:0]  agc_code,
    input logic              pulse_sel,
    input logic              upd_stb,
    input logic              commit,
    input logic [CNT_W-1:0]  bit_cnt
);
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (knee_lvl == '0 && gain_sel == '0 && agc_code == '0
                        && !pulse_sel && !upd_stb));

    p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= CNT_W'(FRAME_BITS));

    p_strobe_single_r8: assert property (@(posedge clk) disable iff (rst)
        upd_stb |=> !upd_stb);

    p_strobe_cause_r8: assert property (@(posedge clk) disable iff (rst)
        upd_stb |-> $past(commit));

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !upd_stb |-> ($stable(knee_lvl) && $stable(gain_sel)
                      && $stable(agc_code) && $stable(pulse_sel)));

    p_knee_group_r4: assert property (@(posedge clk) disable iff (rst)
        (!$stable(knee_lvl) || !$stable(gain_sel))
            |-> ($stable(agc_code) && $stable(pulse_sel)));

    p_agc_group_r5: assert property (@(posedge clk) disable iff (rst)
        !$stable(agc_code) |-> $stable(pulse_sel));
endmodule

bind serial_gain_port serial_gain_port_chk u_chk (
    .clk(clk), .rst(rst),
    .knee_lvl(knee_lvl), .gain_sel(gain_sel), .agc_code(agc_code),
    .pulse_sel(pulse_sel), .upd_stb(upd_stb),
    .commit(commit), .bit_cnt(bit_cnt)
);

// File: tb/sim_serial_gain_port.sv
`timescale 1ns/1ps
module sim_serial_gain_port;

    typedef struct {
        logic [4:0] knee;
        logic [2:0] gsel;
        logic [6:0] agc;
        logic       psel;
        string      tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_clk = 1'b1;
    logic ser_dat = 1'b0;
    logic [4:0] knee_lvl;
    logic [2:0] gain_sel;
    logic [6:0] agc_code;
    logic       pulse_sel;
    logic       upd_stb;

    int n_chk = 0;
    int n_bad = 0;
    int n_stb = 0;
    int n_push = 0;
    bit done = 1'b0;

    exp_t q[$];
    exp_t model;

    always #5 clk = ~clk;

    serial_gain_port u0 (
        .clk(clk), .rst(rst), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .knee_lvl(knee_lvl), .gain_sel(gain_sel), .agc_code(agc_code),
        .pulse_sel(pulse_sel), .upd_stb(upd_stb)
    );

    // Monitor: pop one expected snapshot per strobe (R8)
    always @(negedge clk) begin
        if (!rst && upd_stb) begin
            n_stb++;
            n_chk++;
            if (q.size() == 0) begin
                n_bad++;
                $display("FAIL R8 unexpected strobe: actual=1 expected=0");
            end else begin
                exp_t e;
                e = q.pop_front();
                if (knee_lvl !== e.knee || gain_sel !== e.gsel ||
                    agc_code !== e.agc || pulse_sel !== e.psel) begin
                    n_bad++;
                    $display("FAIL %s actual=%h/%h/%h/%b expected=%h/%h/%h/%b",
                             e.tag, knee_lvl, gain_sel, agc_code, pulse_sel,
                             e.knee, e.gsel, e.agc, e.psel);
                end
            end
        end
    end

    task automatic check_ports(input string tag);
        @(negedge clk);
        n_chk++;
        if (knee_lvl !== model.knee || gain_sel !== model.gsel ||
            agc_code !== model.agc || pulse_sel !== model.psel ||
            n_stb != n_push) begin
            n_bad++;
            $display("FAIL %s actual=%h/%h/%h/%b stb=%0d expected=%h/%h/%h/%b stb=%0d",
                     tag, knee_lvl, gain_sel, agc_code, pulse_sel, n_stb,
                     model.knee, model.gsel, model.agc, model.psel, n_push);
        end
    endtask

    // Driver: d[k-1] holds Dk; D10 sent first.
    task automatic drive(input logic [9:0] d, input logic latch,
                         input int half_ns, input string tag);
        if (latch && d[1:0] != 2'b11) begin
            case (d[1:0])
                2'b00: begin model.knee = d[6:2]; model.gsel = d[9:7]; end
                2'b10: model.agc = d[8:2];
                default: model.psel = d[2];
            endcase
            model.tag = tag;
            q.push_back(model);
            n_push++;
        end
        for (int i = 9; i >= 0; i--) begin
            ser_dat = d[i];
            #(half_ns) ser_clk = 1'b0;
            #(half_ns) ser_clk = 1'b1;
        end
        ser_dat = latch;
        #(half_ns) ser_clk = 1'b0;
        #(half_ns) ser_clk = 1'b1;
        ser_dat = 1'b0;
        #500;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #1900000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            finish_run();
        end
    end

    initial begin
        model = '{knee: 5'd0, gsel: 3'd0, agc: 7'd0, psel: 1'b0, tag: ""};
        repeat (5) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        check_ports("R1 reset state");

        // R4 combined write; R2 bit order; R9 at 2 us period
        drive({3'b011, 5'b10110, 2'b00}, 1'b1, 1000, "R4 knee/gain");
        // R5 AGC write, D10=1 ignored
        drive({1'b1, 7'h5A, 2'b10}, 1'b1, 1000, "R5 agc D10 ignored");
        // R6 pulse bit with junk in D4..D10
        drive({7'b1010110, 1'b1, 2'b01}, 1'b1, 1000, "R6 pulse set");
        // R4 max codes
        drive({3'b111, 5'b11111, 2'b00}, 1'b1, 1000, "R4 max knee/gain");
        drive({1'b0, 7'h7F, 2'b10}, 1'b1, 1000, "R5 agc max");
        drive({1'b1, 7'h00, 2'b10}, 1'b1, 1000, "R5 agc min");
        check_ports("R10 hold after writes");

        // R7 reserved selector committed: no change
        drive({8'b11010101, 2'b11}, 1'b1, 1000, "R7 reserved");
        check_ports("R7 reserved discarded");

        // R3 latch edge low: dropped, next frame still aligned
        drive({3'b000, 5'b00001, 2'b00}, 1'b0, 1000, "R3 no latch");
        check_ports("R3 dropped frame");
        drive({3'b100, 5'b01001, 2'b00}, 1'b1, 1000, "R3 recovery frame");

        // R9 slowest period 20 us
        drive({1'b0, 7'h33, 2'b10}, 1'b1, 10000, "R9 slow agc");
        drive({7'b1111111, 1'b0, 2'b01}, 1'b1, 1000, "R6 pulse clear");
        drive({3'b000, 5'b00000, 2'b00}, 1'b1, 1000, "R4 zero write");
        check_ports("R10 final hold");

        n_chk++;
        if (q.size() != 0) begin
            n_bad++;
            $display("FAIL R8 missing strobes: actual=%0d expected=0 pending", q.size());
        end
        done = 1'b1;
        finish_run();
    end
endmodule